// File: doc/BRIEF.md
# Accumulator ALU Datapath

This block is the arithmetic heart of a fixed-point signal processor: a 32-bit accumulator with an ALU that always takes the accumulator as its first operand. The second operand is either a 32-bit product word from an external multiplier or a 16-bit data-bus word. The data-bus word is sign-extended and scaled left by a programmable amount before use. Every arithmetic or logic result goes back into the accumulator, with optional clamping on signed overflow.

Besides arithmetic, the block stores either half of the accumulator to the data bus through a left shifter without disturbing the accumulator. It normalizes the accumulator one step at a time and reports each step so an outside exponent counter can follow. It tests any single bit of a data word to form a branch condition, and it exposes zero and sign status together with the low accumulator half as a branch target. Operations are chosen by a 4-bit opcode presented with a valid strobe. Each opcode takes one clock.

Top module: `accum_alu`

## Requirements
- R1: After reset the accumulator is 0, `zeroFlag` is 1, and `ovfFlag`, `storeValid`, `bitValid` and `normShifted` are 0.
- R2: The scaled operand is `dataIn` sign-extended to 32 bits and shifted left by `shiftIn` (0 to 15). Opcode 1 loads it into the accumulator, opcode 2 adds it and opcode 3 subtracts it. The result is visible on `accOut` in the cycle after the edge that accepts the opcode.
- R3: Opcode 4 loads `prodIn` into the accumulator, opcode 5 adds it and opcode 6 subtracts it.
- R4: Opcodes 7, 8 and 9 replace the accumulator with its bitwise AND, OR and XOR with the scaled operand.
- R5: Each accumulator-writing opcode (1 to 10) updates `ovfFlag`. It is set to 1 only when an add or subtract overflows the signed 32-bit range and is cleared otherwise. Opcodes that do not write the accumulator leave it unchanged.
- R6: With `satEn` at 1, an overflowing add or subtract writes 0x7FFFFFFF when the true result is too large and 0x80000000 when it is too small. With `satEn` at 0 the result wraps modulo 2^32.
- R7: Opcode 11 stores bits 31:16 and opcode 12 stores bits 15:0 of the accumulator shifted left by `shiftIn[2:0]`. The stored word appears on `storeData` with `storeValid` high for one cycle, and the accumulator is unchanged.
- R8: Opcode 10 shifts the accumulator left by one when it is nonzero and its bits 31 and 30 are equal, and pulses `normShifted` for one cycle. Otherwise the accumulator is left alone and `normShifted` stays 0.
- R9: Opcode 13 sets `bitTrue` to `dataIn[bitSel]` (bit 0 is the least significant bit) and pulses `bitValid` for one cycle. The accumulator is unchanged.
- R10: `zeroFlag` is 1 exactly when the accumulator is 0, `negFlag` equals accumulator bit 31, and `branchAddr` equals accumulator bits 15:0.
- R11: With `opValid` at 0, or with opcode 0, 14 or 15, the accumulator, `ovfFlag` and `storeData` keep their values and no pulse output is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Opcode is valid this cycle |
| opCode | input | 4 | Operation select |
| dataIn | input | 16 | Data-bus word |
| shiftIn | input | 4 | Input scale amount; low 3 bits are the store shift |
| bitSel | input | 4 | Bit index for bit test |
| prodIn | input | 32 | Product register value |
| satEn | input | 1 | Clamp on overflow when 1 |
| accOut | output | 32 | Accumulator |
| zeroFlag | output | 1 | Accumulator is zero |
| negFlag | output | 1 | Accumulator is negative |
| ovfFlag | output | 1 | Last accumulator write overflowed |
| branchAddr | output | 16 | Branch target from accumulator |
| storeData | output | 16 | Shifted accumulator half |
| storeValid | output | 1 | Store result strobe |
| bitTrue | output | 1 | Bit test result |
| bitValid | output | 1 | Bit test strobe |
| normShifted | output | 1 | Normalize step taken |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator, 16-bit data words, a 4-bit input scale and a 3-bit store shift, with saturation logic present. These values cover the largest input scale of 15, where the sign-extended word reaches bit 30. They also cover the largest store shift of 7, where high accumulator bits drop out of the stored half. Saturation in both directions is reached through both operand sources, and the normalize step is tried on positive, negative, zero and already-normal values.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  typedef enum logic [2:0] {
    FN_PASS, FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR
  } aluFn_e;

  typedef struct packed {
    logic   accWr;
    logic   useProd;
    aluFn_e fn;
    logic   norm;
    logic   store;
    logic   storeHi;
    logic   bitTest;
  } ctrlStrb_t;

  localparam logic [3:0] OP_NOP    = 4'd0;
  localparam logic [3:0] OP_LDD    = 4'd1;
  localparam logic [3:0] OP_ADDD   = 4'd2;
  localparam logic [3:0] OP_SUBD   = 4'd3;
  localparam logic [3:0] OP_LDP    = 4'd4;
  localparam logic [3:0] OP_ADDP   = 4'd5;
  localparam logic [3:0] OP_SUBP   = 4'd6;
  localparam logic [3:0] OP_AND    = 4'd7;
  localparam logic [3:0] OP_OR     = 4'd8;
  localparam logic [3:0] OP_XOR    = 4'd9;
  localparam logic [3:0] OP_NORM   = 4'd10;
  localparam logic [3:0] OP_STHI   = 4'd11;
  localparam logic [3:0] OP_STLO   = 4'd12;
  localparam logic [3:0] OP_BTST   = 4'd13;

endpackage

// File: rtl/accum_alu_ctrl.sv
module accum_alu_ctrl
  import accum_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [3:0] opCode,
  output ctrlStrb_t  strb
);

  always_comb begin
    strb = '0;
    strb.fn = FN_PASS;
    if (opValid) begin
      unique case (opCode)
        OP_LDD:  begin strb.accWr = 1'b1; strb.fn = FN_PASS; end
        OP_ADDD: begin strb.accWr = 1'b1; strb.fn = FN_ADD;  end
        OP_SUBD: begin strb.accWr = 1'b1; strb.fn = FN_SUB;  end
        OP_LDP:  begin strb.accWr = 1'b1; strb.useProd = 1'b1; strb.fn = FN_PASS; end
        OP_ADDP: begin strb.accWr = 1'b1; strb.useProd = 1'b1; strb.fn = FN_ADD;  end
        OP_SUBP: begin strb.accWr = 1'b1; strb.useProd = 1'b1; strb.fn = FN_SUB;  end
        OP_AND:  begin strb.accWr = 1'b1; strb.fn = FN_AND; end
        OP_OR:   begin strb.accWr = 1'b1; strb.fn = FN_OR;  end
        OP_XOR:  begin strb.accWr = 1'b1; strb.fn = FN_XOR; end
        OP_NORM: strb.norm = 1'b1;
        OP_STHI: begin strb.store = 1'b1; strb.storeHi = 1'b1; end
        OP_STLO: strb.store = 1'b1;
        OP_BTST: strb.bitTest = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/accum_alu_dp.sv
module accum_alu_dp
  import accum_alu_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int DATA_W   = 16,
  parameter int IN_SH_W  = 4,
  parameter int OUT_SH_W = 3,
  parameter bit HAS_SAT  = 1'b1,
  localparam int BIT_W   = $clog2(DATA_W),
  localparam int MSB     = ACC_W - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrb_t           strb,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [IN_SH_W-1:0]  shiftIn,
  input  logic [BIT_W-1:0]    bitSel,
  input  logic [ACC_W-1:0]    prodIn,
  input  logic                satEn,
  output logic [ACC_W-1:0]    accQ,
  output logic                ovfQ,
  output logic [DATA_W-1:0]   storeQ,
  output logic                storeVldQ,
  output logic                bitQ,
  output logic                bitVldQ,
  output logic                normDoneQ
);

  localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

  logic [ACC_W-1:0] extData, scaled, opB, sum, diff, rawRes, wrRes, outShifted;
  logic             ovfNext, normCan;

  assign extData = {{(ACC_W-DATA_W){dataIn[DATA_W-1]}}, dataIn};
  assign scaled  = extData << shiftIn;
  assign opB     = strb.useProd ? prodIn : scaled;
  assign sum     = accQ + opB;
  assign diff    = accQ - opB;

  always_comb begin
    ovfNext = 1'b0;
    unique case (strb.fn)
      FN_ADD: begin
        rawRes  = sum;
        ovfNext = (accQ[MSB] == opB[MSB]) && (sum[MSB] != accQ[MSB]);
      end
      FN_SUB: begin
        rawRes  = diff;
        ovfNext = (accQ[MSB] != opB[MSB]) && (diff[MSB] != accQ[MSB]);
      end
      FN_AND:  rawRes = accQ & opB;
      FN_OR:   rawRes = accQ | opB;
      FN_XOR:  rawRes = accQ ^ opB;
      default: rawRes = opB;
    endcase
  end

  generate
    if (HAS_SAT) begin : g_sat
      // overflow direction follows the accumulator sign for both add and sub
      assign wrRes = (satEn && ovfNext) ? (accQ[MSB] ? MAX_NEG : MAX_POS) : rawRes;
    end else begin : g_wrap
      assign wrRes = rawRes;
    end
  endgenerate

  assign normCan    = (accQ != '0) && (accQ[MSB] == accQ[MSB-1]);
  assign outShifted = accQ << shiftIn[OUT_SH_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      ovfQ      <= 1'b0;
      storeQ    <= '0;
      storeVldQ <= 1'b0;
      bitQ      <= 1'b0;
      bitVldQ   <= 1'b0;
      normDoneQ <= 1'b0;
    end else begin
      storeVldQ <= strb.store;
      bitVldQ   <= strb.bitTest;
      normDoneQ <= strb.norm && normCan;
      if (strb.accWr) begin
        accQ <= wrRes;
        ovfQ <= ovfNext;
      end else if (strb.norm) begin
        ovfQ <= 1'b0;
        if (normCan) accQ <= accQ << 1;
      end
      if (strb.store)
        storeQ <= strb.storeHi ? outShifted[ACC_W-1 -: DATA_W] : outShifted[DATA_W-1:0];
      if (strb.bitTest)
        bitQ <= dataIn[bitSel];
    end
  end

  // R7
  store_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.store |=> (accQ == $past(accQ)));

  // R6
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (HAS_SAT && satEn && strb.accWr && ovfNext) |=> (accQ == MAX_POS || accQ == MAX_NEG));

  // R8
  norm_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    normDoneQ |-> (accQ == ($past(accQ) << 1)) && ($past(accQ[MSB]) == $past(accQ[MSB-1])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.accWr || strb.norm || strb.store) |=> (accQ == $past(accQ)) && (ovfQ == $past(ovfQ))
      && (storeQ == $past(storeQ)));

  // R5
  ovf_only_arith_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfQ) |-> $past(strb.accWr) && ($past(strb.fn) == FN_ADD || $past(strb.fn) == FN_SUB));

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
#(
  parameter int ACC_W    = 32,
  parameter int DATA_W   = 16,
  parameter int IN_SH_W  = 4,
  parameter int OUT_SH_W = 3,
  parameter bit HAS_SAT  = 1'b1,
  localparam int BIT_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [3:0]          opCode,
  input  logic [DATA_W-1:0]   dataIn,
  input  logic [IN_SH_W-1:0]  shiftIn,
  input  logic [BIT_W-1:0]    bitSel,
  input  logic [ACC_W-1:0]    prodIn,
  input  logic                satEn,
  output logic [ACC_W-1:0]    accOut,
  output logic                zeroFlag,
  output logic                negFlag,
  output logic                ovfFlag,
  output logic [DATA_W-1:0]   branchAddr,
  output logic [DATA_W-1:0]   storeData,
  output logic                storeValid,
  output logic                bitTrue,
  output logic                bitValid,
  output logic                normShifted
);

  ctrlStrb_t strb;

  accum_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .strb    (strb)
  );

  accum_alu_dp #(
    .ACC_W    (ACC_W),
    .DATA_W   (DATA_W),
    .IN_SH_W  (IN_SH_W),
    .OUT_SH_W (OUT_SH_W),
    .HAS_SAT  (HAS_SAT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataIn    (dataIn),
    .shiftIn   (shiftIn),
    .bitSel    (bitSel),
    .prodIn    (prodIn),
    .satEn     (satEn),
    .accQ      (accOut),
    .ovfQ      (ovfFlag),
    .storeQ    (storeData),
    .storeVldQ (storeValid),
    .bitQ      (bitTrue),
    .bitVldQ   (bitValid),
    .normDoneQ (normShifted)
  );

  assign zeroFlag   = (accOut == '0);
  assign negFlag    = accOut[ACC_W-1];
  assign branchAddr = accOut[DATA_W-1:0];

endmodule

// File: tb/accum_alu_tb.sv
module accum_alu_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [15:0] dataIn = '0;
  logic [3:0]  shiftIn = '0;
  logic [3:0]  bitSel = '0;
  logic [31:0] prodIn = '0;
  logic        satEn = 1'b0;
  logic [31:0] accOut;
  logic        zeroFlag, negFlag, ovfFlag, storeValid, bitTrue, bitValid, normShifted;
  logic [15:0] branchAddr, storeData;

  int nChecks = 0;
  int nFails = 0;

  always #10 clk = ~clk;

  accum_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .dataIn(dataIn),
    .shiftIn(shiftIn), .bitSel(bitSel), .prodIn(prodIn), .satEn(satEn),
    .accOut(accOut), .zeroFlag(zeroFlag), .negFlag(negFlag), .ovfFlag(ovfFlag),
    .branchAddr(branchAddr), .storeData(storeData), .storeValid(storeValid),
    .bitTrue(bitTrue), .bitValid(bitValid), .normShifted(normShifted)
  );

  typedef struct {
    logic [31:0] acc;
    logic        ovf;
    logic        stV;
    logic [15:0] st;
    logic        bV;
    logic        bt;
    logic        nm;
    int          req;
  } expItem_t;

  expItem_t scb[$];

  logic [31:0] mAcc = '0;
  logic        mOvf = 1'b0;
  logic [15:0] mSt = '0;
  logic        mBit = 1'b0;

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: applies one opcode and pushes what the outputs must show after the next edge
  task automatic doOp(input int req, input logic vld, input logic [3:0] op, input logic [15:0] d,
                      input logic [3:0] sh, input logic [3:0] bs, input logic [31:0] p, input logic sat);
    expItem_t it;
    logic [31:0] sc, b;
    longint tru;
    logic isArith, isSub;
    @(negedge clk);
    opValid = vld; opCode = op; dataIn = d; shiftIn = sh; bitSel = bs; prodIn = p; satEn = sat;
    sc = {{16{d[15]}}, d} << sh;
    b  = (op >= 4 && op <= 6) ? p : sc;
    it.stV = 1'b0; it.bV = 1'b0; it.nm = 1'b0; it.req = req;
    if (vld && op >= 1 && op <= 9) begin
      isArith = (op == 2 || op == 3 || op == 5 || op == 6);
      isSub   = (op == 3 || op == 6);
      tru = isSub ? (longint'($signed(mAcc)) - longint'($signed(b)))
                  : (longint'($signed(mAcc)) + longint'($signed(b)));
      mOvf = isArith && (tru > 64'sd2147483647 || tru < -64'sd2147483648);
      case (op)
        7: mAcc = mAcc & b;
        8: mAcc = mAcc | b;
        9: mAcc = mAcc ^ b;
        1, 4: mAcc = b;
        default: mAcc = (mOvf && sat) ? ((tru > 0) ? 32'h7FFFFFFF : 32'h80000000) : tru[31:0];
      endcase
    end else if (vld && op == 10) begin
      mOvf = 1'b0;
      if (mAcc != 0 && mAcc[31] == mAcc[30]) begin
        mAcc = {mAcc[30:0], 1'b0};
        it.nm = 1'b1;
      end
    end else if (vld && (op == 11 || op == 12)) begin
      logic [31:0] s;
      s = mAcc << sh[2:0];
      mSt = (op == 11) ? s[31:16] : s[15:0];
      it.stV = 1'b1;
    end else if (vld && op == 13) begin
      mBit = d[bs];
      it.bV = 1'b1;
    end
    it.acc = mAcc; it.ovf = mOvf; it.st = mSt; it.bt = mBit;
    scb.push_back(it);
  endtask

  // monitor: pops one expected item after each edge that consumed an opcode
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (scb.size() > 0) begin
        expItem_t e;
        e = scb.pop_front();
        check(e.req, "acc", accOut, e.acc);
        check(10, "zeroFlag", 32'(zeroFlag), 32'(e.acc == 0));   // R10
        check(10, "negFlag", 32'(negFlag), 32'(e.acc[31]));      // R10
        check(10, "branchAddr", 32'(branchAddr), 32'(e.acc[15:0]));
        check(5, "ovfFlag", 32'(ovfFlag), 32'(e.ovf));           // R5
        check(e.req, "storeValid", 32'(storeValid), 32'(e.stV));
        check(e.req, "storeData", 32'(storeData), 32'(e.st));
        check(e.req, "bitValid", 32'(bitValid), 32'(e.bV));
        if (e.bV) check(e.req, "bitTrue", 32'(bitTrue), 32'(e.bt));
        check(e.req, "normShifted", 32'(normShifted), 32'(e.nm));
      end
    end
  end

  initial begin
    #(200000 * 20);
    nFails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(1, "acc", accOut, 32'h0);
    check(1, "zeroFlag", 32'(zeroFlag), 32'h1);
    check(1, "ovfFlag", 32'(ovfFlag), 32'h0);
    check(1, "pulses", {29'h0, storeValid, bitValid, normShifted}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R2 scaled data operand
    doOp(2, 1, 4'd1, 16'h8000, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(2, 1, 4'd1, 16'h1234, 4'd15, 4'd0, 32'h0, 1'b0);
    doOp(2, 1, 4'd1, 16'hFFFF, 4'd15, 4'd0, 32'h0, 1'b0);
    doOp(2, 1, 4'd2, 16'h0001, 4'd3, 4'd0, 32'h0, 1'b0);
    doOp(2, 1, 4'd3, 16'h0100, 4'd8, 4'd0, 32'h0, 1'b0);
    // R3 product operand
    doOp(3, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h1234_5678, 1'b0);
    doOp(3, 1, 4'd5, 16'h0, 4'd0, 4'd0, 32'h0101_0101, 1'b0);
    doOp(3, 1, 4'd6, 16'h0, 4'd0, 4'd0, 32'h2000_0000, 1'b0);
    // R4 logic ops
    doOp(4, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'hF0F0_5A5A, 1'b0);
    doOp(4, 1, 4'd7, 16'h0FF0, 4'd4, 4'd0, 32'h0, 1'b0);
    doOp(4, 1, 4'd8, 16'h8001, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(4, 1, 4'd9, 16'h1234, 4'd2, 4'd0, 32'h0, 1'b0);
    // R5 R6 overflow wrap then clear
    doOp(6, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h7FFF_FFFF, 1'b0);
    doOp(6, 1, 4'd2, 16'h0001, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(5, 1, 4'd1, 16'h0001, 4'd0, 4'd0, 32'h0, 1'b0);
    // R6 clamp positive and negative, both sources
    doOp(6, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h7FFF_FFF0, 1'b1);
    doOp(6, 1, 4'd5, 16'h0, 4'd0, 4'd0, 32'h0000_0100, 1'b1);
    doOp(6, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h8000_0000, 1'b1);
    doOp(6, 1, 4'd3, 16'h0001, 4'd0, 4'd0, 32'h0, 1'b1);
    doOp(6, 1, 4'd1, 16'h0000, 4'd0, 4'd0, 32'h0, 1'b1);
    doOp(6, 1, 4'd6, 16'h0, 4'd0, 4'd0, 32'h8000_0000, 1'b1);
    doOp(6, 1, 4'd1, 16'h8000, 4'd15, 4'd0, 32'h0, 1'b1);
    doOp(6, 1, 4'd2, 16'h8000, 4'd15, 4'd0, 32'h0, 1'b1);
    // R11 idle cycles keep state
    doOp(11, 0, 4'd2, 16'h7777, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(11, 1, 4'd14, 16'h7777, 4'd0, 4'd0, 32'h5, 1'b0);
    doOp(11, 1, 4'd0, 16'h7777, 4'd0, 4'd0, 32'h5, 1'b0);
    // R7 stores
    doOp(7, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h1234_5678, 1'b0);
    doOp(7, 1, 4'd11, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(7, 1, 4'd12, 16'h0, 4'd4, 4'd0, 32'h0, 1'b0);
    doOp(7, 1, 4'd11, 16'h0, 4'd7, 4'd0, 32'h0, 1'b0);
    doOp(7, 1, 4'd12, 16'h0, 4'd15, 4'd0, 32'h0, 1'b0);
    doOp(11, 1, 4'd15, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    // R8 normalize
    doOp(8, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h0040_0000, 1'b0);
    doOp(8, 1, 4'd10, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(8, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h4000_0000, 1'b0);
    doOp(8, 1, 4'd10, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(8, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'hFFFF_FFFF, 1'b0);
    doOp(8, 1, 4'd10, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(8, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    doOp(8, 1, 4'd10, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);
    // R9 bit test
    doOp(9, 1, 4'd13, 16'h8001, 4'd0, 4'd15, 32'h0, 1'b0);
    doOp(9, 1, 4'd13, 16'h8001, 4'd0, 4'd1, 32'h0, 1'b0);
    doOp(9, 1, 4'd13, 16'h8001, 4'd0, 4'd0, 32'h0, 1'b0);
    // R10 branch address from a mixed value
    doOp(10, 1, 4'd4, 16'h0, 4'd0, 4'd0, 32'hCAFE_BEEF, 1'b0);
    doOp(11, 0, 4'd0, 16'h0, 4'd0, 4'd0, 32'h0, 1'b0);

    @(negedge clk);
    opValid = 1'b0;
    while (scb.size() > 0) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule